// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector with Receive Mute

The block watches a received serial line, one bit per clock, and keeps a loss-of-signal (LOS) flag. The flag is raised when the line has stayed at zero for a long unbroken stretch. It is dropped again only when enough bit-to-bit transitions have been seen within a sliding window of recent bit periods. A steady line sets the flag quickly. Clearing needs real activity, so the flag has hysteresis that is not symmetric.

The flag is combined with an active-low signal-detect input from the optics and an active-high monitor-disable input. The result gates the 8-bit parallel receive word to all zeros. The gate decision is taken only on word boundaries, which the byte strobe marks, so a word is never partly muted. The combined mute state is also brought out.

Top module: `los_mute_top`

## Requirements
- R1: While reset is asserted and right after it is released, `los_flag` is 1, `mute` is 1 and `par_out` is all zeros.
- R2: With `mon_dis` low, `los_flag` rises at the clock edge that samples the 128th consecutive zero on `bit_in`. A run of 127 zeros followed by a one leaves the flag unchanged.
- R3: With `mon_dis` low and `los_flag` high, the flag falls at the edge where the number of transitions among the most recent 128 bit periods (the current one included) reaches 16. A count of 15 or fewer keeps it high.
- R4: A transition is a bit that differs from the previous bit, and the bit before the first bit after reset counts as 0. A steady run of ones therefore adds no transitions and never clears the flag.
- R5: A transition leaves the window 128 bit periods after it entered. Transitions that are older than that do not count toward clearing.
- R6: At a strobe edge where `los_flag` is 1 and `mon_dis` is 0, the word loaded into `par_out` is all zeros and `mute` becomes 1.
- R7: At a strobe edge where `sd_n` is 0, the word loaded is all zeros and `mute` becomes 1, whatever `los_flag` and `mon_dis` are.
- R8: While `mon_dis` is high, `los_flag` is forced low at every edge and the internal flag causes no muting. The zero-run and window counters keep running.
- R9: `par_out` and `mute` change only at edges where `byte_stb` is high. At an unmuted strobe edge, `par_out` loads `par_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial line bit for this cycle |
| byte_stb | input | 1 | High on the last bit cycle of each parallel word |
| par_in | input | 8 | Parallel receive word, valid at the strobe |
| mon_dis | input | 1 | High turns off internal LOS monitoring and its muting |
| sd_n | input | 1 | External signal detect, low forces muting |
| los_flag | output | 1 | Internal loss-of-signal flag |
| mute | output | 1 | 1 when the word on `par_out` was muted |
| par_out | output | 8 | Gated parallel receive word |

## Verification
The line is driven with several patterns. Steady ones show that a stuck-high line is not activity. Zero runs of 120 and 128 bits find the exact declare point. Alternating bits clear the flag at the 16th transition. Sparse single-one words give too few transitions to clear. The control inputs are then crossed with line states: disable over a dead line, signal-detect low over a live line, and both together. This separates the internal mute path from the external one. A signal-detect change in the middle of a word, followed by a reset in the middle of the stream, shows that the output moves only at word boundaries and that reset puts the block back into LOS.

// File: rtl/los_pkg.sv
package los_pkg;

  // Next value of the zero-run counter, saturating at lim.
  function automatic logic [15:0] zrun_next(input logic [15:0] cur,
                                            input logic bit_v,
                                            input logic [15:0] lim);
    if (bit_v) return 16'd0;
    if (cur >= lim) return lim;
    return cur + 16'd1;
  endfunction

  // Running transition count: add the newest flag, drop the oldest.
  function automatic logic [15:0] win_next(input logic [15:0] cur,
                                           input logic add_v,
                                           input logic drop_v);
    return cur + {15'd0, add_v} - {15'd0, drop_v};
  endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int ZRUN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic zero_hit
);
  localparam int CW = $clog2(ZRUN + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    run_d    = CW'(los_pkg::zrun_next(16'(run_q), bit_in, 16'(ZRUN)));
    zero_hit = (32'(run_d) >= ZRUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_q) <= ZRUN); // R2
  AST_ONE_RESETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_in |=> (run_q == '0)); // R2
endmodule

// File: rtl/los_trans_window.sv
module los_trans_window #(
  parameter int WIN       = 128,
  parameter int TRANS_MIN = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_in,
  output logic                       clear_ok,
  output logic [$clog2(WIN+1)-1:0]   trans_cnt
);
  localparam int CW = $clog2(WIN + 1);

  logic           prev_q;
  logic           tflag;
  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  cnt_d;

  always_comb begin
    tflag    = bit_in ^ prev_q;
    cnt_d    = CW'(los_pkg::win_next(16'(trans_cnt), tflag, hist_q[WIN-1]));
    clear_ok = (32'(cnt_d) >= TRANS_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      hist_q    <= '0;
      trans_cnt <= '0;
    end else begin
      prev_q    <= bit_in;
      hist_q    <= {hist_q[WIN-2:0], tflag};
      trans_cnt <= cnt_d;
    end
  end

  AST_WIN_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    32'(trans_cnt) == $countones(hist_q)); // R5
  AST_WIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(trans_cnt) <= WIN); // R5
endmodule

// File: rtl/los_word_gate.sv
module los_word_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic          mute_req,
  input  logic [DW-1:0] par_in,
  output logic [DW-1:0] par_out,
  output logic          mute_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= '0;
      mute_o  <= 1'b1;
    end else if (byte_stb) begin
      par_out <= mute_req ? '0 : par_in;
      mute_o  <= mute_req;
    end
  end

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> $stable(par_out) && $stable(mute_o)); // R9
  AST_MUTED_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o |-> (par_out == '0)); // R6
endmodule

// File: rtl/los_mute_top.sv
module los_mute_top #(
  parameter int DW        = 8,
  parameter int ZRUN      = 128,
  parameter int WIN       = 128,
  parameter int TRANS_MIN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          byte_stb,
  input  logic [DW-1:0] par_in,
  input  logic          mon_dis,
  input  logic          sd_n,
  output logic          los_flag,
  output logic          mute,
  output logic [DW-1:0] par_out
);
  localparam int CW = $clog2(WIN + 1);

  logic          zero_hit;
  logic          clear_ok;
  logic [CW-1:0] trans_cnt;
  logic          mute_req;

  los_zero_run #(.ZRUN(ZRUN)) u_zero (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .zero_hit(zero_hit)
  );

  los_trans_window #(.WIN(WIN), .TRANS_MIN(TRANS_MIN)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
    .clear_ok(clear_ok), .trans_cnt(trans_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   los_flag <= 1'b1;
    else if (mon_dis)             los_flag <= 1'b0;
    else if (zero_hit)            los_flag <= 1'b1;
    else if (los_flag && clear_ok) los_flag <= 1'b0;
  end

  assign mute_req = (los_flag && !mon_dis) || !sd_n;

  los_word_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .mute_req(mute_req),
    .par_in(par_in), .par_out(par_out), .mute_o(mute)
  );

  AST_DECLARE_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit && !mon_dis |=> los_flag); // R2
  AST_CLEAR_NEEDS_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_flag) |-> (32'(trans_cnt) >= TRANS_MIN) || $past(mon_dis)); // R3
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    mon_dis |=> !los_flag); // R8
  AST_SD_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb && !sd_n |=> mute && (par_out == '0)); // R7
  AST_LOS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb && los_flag && !mon_dis |=> mute); // R6
endmodule

// File: tb/los_mute_top_bench.sv
module los_mute_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 12;
  // {pattern[7:0], words[15:0], sd_n, mon_dis}
  localparam logic [25:0] SEG [NSEG] = '{
    {8'hFF, 16'd2,  1'b1, 1'b0},
    {8'hAA, 16'd2,  1'b1, 1'b0},
    {8'hFF, 16'd1,  1'b1, 1'b0},
    {8'h00, 16'd15, 1'b1, 1'b0},
    {8'hFF, 16'd1,  1'b1, 1'b0},
    {8'h00, 16'd16, 1'b1, 1'b0},
    {8'h80, 16'd3,  1'b1, 1'b0},
    {8'hAA, 16'd4,  1'b1, 1'b0},
    {8'h00, 16'd17, 1'b1, 1'b1},
    {8'h55, 16'd4,  1'b0, 1'b0},
    {8'h00, 16'd17, 1'b0, 1'b1},
    {8'hCC, 16'd8,  1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       byte_stb = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       mon_dis = 1'b0;
  logic       sd_n = 1'b1;
  logic       los_flag;
  logic       mute;
  logic [7:0] par_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit   m_prev;
  bit   m_tf [128];
  int   m_zrun;
  bit   m_los;
  bit   m_mute;
  logic [7:0] m_out;

  los_mute_top u_los_mute_top (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .byte_stb(byte_stb),
    .par_in(par_in), .mon_dis(mon_dis), .sd_n(sd_n),
    .los_flag(los_flag), .mute(mute), .par_out(par_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = 1'b0;
    for (int i = 0; i < 128; i++) m_tf[i] = 1'b0;
    m_zrun = 0;
    m_los  = 1'b1;
    m_mute = 1'b1;
    m_out  = 8'h00;
  endtask

  // Drive one bit cycle at the falling edge, predict, then check after the edge.
  task automatic cyc(input bit b, input bit stb, input logic [7:0] d,
                     input bit sdn, input bit dis, input string req);
    bit los_old;
    int tcnt;
    bit_in = b; byte_stb = stb; par_in = d; sd_n = sdn; mon_dis = dis;
    for (int i = 127; i > 0; i--) m_tf[i] = m_tf[i-1];
    m_tf[0] = b ^ m_prev;
    m_prev  = b;
    m_zrun  = b ? 0 : m_zrun + 1;
    tcnt = 0;
    for (int i = 0; i < 128; i++) tcnt += int'(m_tf[i]);
    los_old = m_los;
    if (dis)                      m_los = 1'b0;
    else if (m_zrun >= 128)       m_los = 1'b1;
    else if (m_los && tcnt >= 16) m_los = 1'b0;
    if (stb) begin
      m_mute = (los_old && !dis) || !sdn;
      m_out  = m_mute ? 8'h00 : d;
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " los_flag"}, int'(los_flag), int'(m_los));
    chk({req, " mute R9"}, int'(mute), int'(m_mute));
    chk({req, " par_out R9"}, int'(par_out), int'(m_out));
  endtask

  function automatic string seg_tag(input int s);
    case (s)
      0: return "R4";
      1: return "R3";
      3: return "R2";
      5: return "R2 R6";
      6: return "R5";
      7: return "R3";
      8: return "R8";
      9: return "R7";
      10: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int wcount;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 los_flag in reset", int'(los_flag), 1);
    chk("R1 mute in reset", int'(mute), 1);
    chk("R1 par_out in reset", int'(par_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 los_flag after release", int'(los_flag), 1);
    chk("R1 mute after release", int'(mute), 1);

    wcount = 0;
    for (int s = 0; s < NSEG; s++) begin
      logic [7:0] pat;
      int nw;
      pat = SEG[s][25:18];
      nw  = int'(SEG[s][17:2]);
      for (int w = 0; w < nw; w++) begin
        logic [7:0] d;
        d = 8'(wcount * 37 + 5);
        wcount++;
        for (int i = 0; i < 8; i++)
          cyc(pat[7-i], i == 7, d, SEG[s][1], SEG[s][0], seg_tag(s));
      end
    end

    // Directed: sd_n goes low in the middle of a word; output waits for the strobe.
    for (int i = 0; i < 8; i++) cyc(i[0], i == 7, 8'h3C, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 8; i++) cyc(i[0], i == 7, 8'h5A, i < 3, 1'b0, "R9 R7");
    chk("R7 word after sd_n low", int'(par_out), 0);

    // Directed: reset in the middle of a live stream.
    cyc(1'b1, 1'b0, 8'h11, 1'b1, 1'b0, "R9");
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 los_flag mid-stream reset", int'(los_flag), 1);
    chk("R1 mute mid-stream reset", int'(mute), 1);
    chk("R1 par_out mid-stream reset", int'(par_out), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b1, i == 7, 8'h77, 1'b1, 1'b0, "R4 R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule